// File: doc/BRIEF.md
# Glitch-free clock output selector

This block drives a clock output pin from one of two sources. The first source is a high-speed oscillator clock, divided by a selectable power of two. The second is a reference clock. Switching between the two sources never produces a short pulse. The outgoing clock is parked high. The incoming clock takes over at its own falling edge. The changeover uses a two-register synchronizing handshake in each clock domain.

A small configuration register, clocked by the reference clock, holds three control bits:
- a select bit that chooses the reference source,
- a disable bit that forces the output into three-state,
- a pin-role bit that decides what a multipurpose input pin does.

With the role bit clear, the pin is an active-high output enable. With the role bit set, the pin becomes an external reference-select, which is ORed with the register's select bit. The three-state condition is presented on a separate active-low enable output, `oe_n`, next to the clock. A pad cell or a testbench can use it directly.

Top module: `clkout_switch`

## Requirements
- R1: After reset the configuration register holds 3'b010. The output follows the reference clock. The pin acts as an output enable, so with the pin high `oe_n` is 0.
- R2: When the divided path is selected, the output period is the oscillator period times 2^`div_sel`. `div_sel` = 0 gives divide by 1, and 7 gives divide by 128.
- R3: An effective select of 1 routes the reference clock to `clk_out`. An effective select of 0 routes the divided oscillator clock.
- R4: On a rising reference-clock edge with `cfg_we` high, the register loads `cfg_wdata`. Bit 0 is the disable bit, bit 1 is the select bit and bit 2 is the pin-role bit. With `cfg_we` low, changes on `cfg_wdata` have no effect.
- R5: A disable bit of 1 drives `oe_n` to 1, whichever source is selected and whatever the pin level.
- R6: With pin-role 0, a low pin drives `oe_n` to 1 and a high pin enables the output. The pin level does not affect source selection.
- R7: With pin-role 1, the effective select is the register select bit ORed with the pin level. The pin no longer gates `oe_n`.
- R8: During any changeover, `clk_out` never shows a high or low pulse shorter than the shorter half period of the two clocks. While neither source is engaged, `clk_out` is held high.
- R9: After the select changes, `clk_out` follows the new source within two cycles of the departing clock plus two cycles of the arriving clock.
- R10: A single register write that both changes the select and sets the disable bit gives three-state at once. The source changeover still completes while the output is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_clk | input | 1 | Reference clock; also clocks the configuration register |
| osc_clk | input | 1 | High-speed oscillator clock |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 3 | Configuration data: bit 0 disable, bit 1 select, bit 2 pin role |
| div_sel | input | DIV_BITS | Post-divide exponent for the oscillator clock |
| mux_pin | input | 1 | Multipurpose pin: output enable or external select |
| clk_out | output | 1 | Selected clock |
| oe_n | output | 1 | Active-low output enable for the clock pad |

## Verification
The output-disable path and the source handover can change on the same reference edge. This happens when one register write flips the select bit and sets the disable bit together. The bench issues such writes in both directions. It requires `oe_n` to rise right after the write. After re-enabling, it measures the output period to confirm that the handover finished underneath the disable. A pulse-width monitor runs through the whole run, so a sliver produced by either event is counted against R8.

// File: rtl/clkout_switch.sv
module clkout_switch #(
  parameter int DIV_BITS    = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                rst_n,
  input  logic                ref_clk,
  input  logic                osc_clk,
  input  logic                cfg_we,
  input  logic [2:0]          cfg_wdata,
  input  logic [DIV_BITS-1:0] div_sel,
  input  logic                mux_pin,
  output logic                clk_out,
  output logic                oe_n
);
  localparam int         CNT_W     = (1 << DIV_BITS) - 1;
  localparam logic [2:0] CFG_RESET = 3'b010;

  logic [2:0] cfg_q;
  logic       sel_eff;
  logic       div_clk;
  logic       div_en;
  logic       ref_en;
  logic [CNT_W-1:0]       cnt;
  logic [CNT_W:0]         taps;
  logic [SYNC_STAGES-1:0] ref_sync;
  logic [SYNC_STAGES-1:0] div_sync;

  always_ff @(posedge ref_clk or negedge rst_n)
    if (!rst_n)      cfg_q <= CFG_RESET;
    else if (cfg_we) cfg_q <= cfg_wdata;

  assign sel_eff = cfg_q[1] | (cfg_q[2] & mux_pin);
  assign oe_n    = cfg_q[0] | (~cfg_q[2] & ~mux_pin);

  always_ff @(posedge osc_clk or negedge rst_n)
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + 1'b1;

  assign taps    = {cnt, osc_clk};
  assign div_clk = taps[div_sel];

  generate
    if (SYNC_STAGES > 1) begin : g_deep
      always_ff @(posedge ref_clk or negedge rst_n)
        if (!rst_n) ref_sync <= '1;
        else        ref_sync <= {ref_sync[SYNC_STAGES-2:0], sel_eff & ~div_en};
      always_ff @(posedge div_clk or negedge rst_n)
        if (!rst_n) div_sync <= '0;
        else        div_sync <= {div_sync[SYNC_STAGES-2:0], ~sel_eff & ~ref_en};
    end else begin : g_single
      always_ff @(posedge ref_clk or negedge rst_n)
        if (!rst_n) ref_sync <= '1;
        else        ref_sync <= sel_eff & ~div_en;
      always_ff @(posedge div_clk or negedge rst_n)
        if (!rst_n) div_sync <= '0;
        else        div_sync <= ~sel_eff & ~ref_en;
    end
  endgenerate

  assign ref_en  = ref_sync[SYNC_STAGES-1];
  assign div_en  = div_sync[SYNC_STAGES-1];
  assign clk_out = (div_clk | ~div_en) & (ref_clk | ~ref_en);

  p_excl_r8: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !(div_en && ref_en));
  p_park_high_r8: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (!div_en && !ref_en) |-> clk_out);
  p_ref_take_r3: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(ref_en) |-> !div_en);
  p_div_take_r3: assert property (@(posedge div_clk) disable iff (!rst_n)
    $rose(div_en) |-> !ref_en);
  p_disable_r5: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (cfg_we && cfg_wdata[0]) |=> oe_n);
endmodule

// File: tb/clkout_switch_tb.sv
`timescale 1ns/1ps
module clkout_switch_tb_top;
  logic       rst_n = 1'b0;
  logic       ref_clk = 1'b0;
  logic       osc_clk = 1'b0;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_wdata = 3'b010;
  logic [2:0] div_sel = 3'd0;
  logic       mux_pin = 1'b1;
  logic       clk_out;
  logic       oe_n;
  real        osc_half = 2.0;

  int errors = 0;
  int checks = 0;
  int glitches = 0;
  bit mon = 1'b0;
  bit have_last = 1'b0;
  realtime last_edge = 0;

  localparam int VEC_M[8] = '{0, 1, 2, 3, 4, 5, 6, 7};
  localparam int VEC_H[8] = '{2, 3, 2, 4, 2, 3, 2, 2};

  clkout_switch dut_i (
    .rst_n(rst_n), .ref_clk(ref_clk), .osc_clk(osc_clk),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .div_sel(div_sel),
    .mux_pin(mux_pin), .clk_out(clk_out), .oe_n(oe_n)
  );

  always #5 ref_clk = ~ref_clk;
  always #(osc_half) osc_clk = ~osc_clk;

  always @(clk_out) begin
    if (mon) begin
      if (have_last && ($realtime - last_edge) < 1.9) glitches++;
      last_edge = $realtime;
      have_last = 1'b1;
    end
  end

  task automatic chk_bit(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic chk_period(string tag, realtime exp);
    realtime t0, p;
    @(posedge clk_out); t0 = $realtime;
    @(posedge clk_out); p = $realtime - t0;
    checks++;
    if (p < exp - 0.05 || p > exp + 0.05) begin
      errors++;
      $display("FAIL %s: actual=%0.3f expected=%0.3f", tag, p, exp);
    end
  endtask

  task automatic write_cfg(logic [2:0] v);
    @(negedge ref_clk); cfg_wdata = v; cfg_we = 1'b1;
    @(negedge ref_clk); cfg_we = 1'b0;
    #1;
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge ref_clk);
    #1;
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #3000000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
  end

  initial begin
    settle(5);
    rst_n = 1'b1;
    mon = 1'b1;
    settle(5);
    chk_bit("R1 reset oe_n", oe_n, 1'b0);
    chk_period("R1 reset source is reference", 10.0);

    for (int i = 0; i < 8; i++) begin
      write_cfg(3'b010);
      settle(300);
      osc_half = VEC_H[i];
      div_sel  = VEC_M[i][2:0];
      settle(5);
      write_cfg(3'b000);
      settle(300);
      chk_period($sformatf("R2 divide m=%0d", VEC_M[i]),
                 2.0 * VEC_H[i] * (1 << VEC_M[i]));
    end

    write_cfg(3'b010);
    settle(300);
    osc_half = 2.0;
    div_sel  = 3'd0;
    settle(10);

    write_cfg(3'b000);
    settle(10);
    chk_period("R9 R3 release to divided", 4.0);
    write_cfg(3'b010);
    settle(10);
    chk_period("R9 R3 select reference", 10.0);

    cfg_wdata = 3'b001;
    settle(3);
    chk_bit("R4 no write without strobe", oe_n, 1'b0);
    chk_period("R4 source unchanged without strobe", 10.0);

    write_cfg(3'b011);
    chk_bit("R5 disable on reference", oe_n, 1'b1);
    write_cfg(3'b010);
    chk_bit("R5 re-enable", oe_n, 1'b0);

    write_cfg(3'b001);
    chk_bit("R10 disable with switch to divided", oe_n, 1'b1);
    settle(20);
    write_cfg(3'b000);
    chk_bit("R10 enabled again", oe_n, 1'b0);
    chk_period("R10 handover done under disable", 4.0);
    write_cfg(3'b011);
    chk_bit("R10 disable with switch to reference", oe_n, 1'b1);
    settle(20);
    write_cfg(3'b010);
    chk_period("R10 reference after disable", 10.0);

    write_cfg(3'b000);
    mux_pin = 1'b1;
    settle(10);
    chk_bit("R6 pin high enables", oe_n, 1'b0);
    chk_period("R6 pin high does not select", 4.0);
    mux_pin = 1'b0;
    #1;
    chk_bit("R6 pin low three-states", oe_n, 1'b1);

    write_cfg(3'b100);
    settle(10);
    chk_bit("R7 pin no longer enable", oe_n, 1'b0);
    chk_period("R7 pin low selects divided", 4.0);
    mux_pin = 1'b1;
    settle(10);
    chk_period("R7 pin high selects reference", 10.0);
    mux_pin = 1'b0;
    settle(10);
    chk_period("R7 pin released", 4.0);
    write_cfg(3'b110);
    settle(10);
    chk_period("R7 register bit ORed with pin", 10.0);
    write_cfg(3'b101);
    chk_bit("R5 disable with pin as select", oe_n, 1'b1);

    settle(10);
    mon = 1'b0;
    checks++;
    if (glitches != 0) begin
      errors++;
      $display("FAIL R8 short pulses: actual=%0d expected=0", glitches);
    end
    summary();
  end
endmodule